// File: doc/BRIEF.md
# Layer-1 Indication and S-Channel Change Register Bank

This block sits between a line-interface front end and a microprocessor. Every clock cycle it samples two 4-bit codes from the front end: a layer-1 indication code and an S-channel code. A change in either code is reported to the host through a status bit. Indication codes are queued two deep, so a second change that arrives before the host has read the first is not lost. Each change flag clears only when the host reads the register that holds that flag's data.

The host port is a plain synchronous register port with a 2-bit address, separate read and write strobes, and 8-bit write and read data. `rdata` follows `addr` combinationally. A read has side effects only at the rising edge where `rd_en` is high. The code inputs are level signals with no handshake: the front end holds each code until the next one, and the block compares each sample with the last one it stored. The register map is:
- address 0: receive status, read-only: bit 7 is the S-channel change flag, bit 6 is the indication change flag, bits 5..4 are zero and bits 3..0 hold the indication code.
- address 1: S-channel code, read-only.
- address 2: transmit command, read/write.
- address 3: unused, reads zero.

Code 4'b1111 means idle or deactivation confirmed, and 4'b0111 means power-up. The block does not interpret these codes.

Top module: `l1ind_regs`

## Requirements
- R1: After `rst_n` is low, address 0 reads 0x0F, address 1 reads 0x0F, address 2 reads 0x0F and `cmd_code_o` is 4'hF.
- R2: At each rising edge, the indication input is accepted only if it differs from the most recently accepted code; the last accepted code is 4'hF after reset. While the buffer is empty, status bits 3..0 show the last accepted code.
- R3: Accepted codes enter a buffer two entries deep. When both entries are full, a newly accepted code overwrites the newest entry, and the oldest entry is kept.
- R4: While the buffer holds any entry, status bits 3..0 show the oldest entry and bit 6 reads 1. A read of address 0 removes that entry, so bit 6 stays 1 while another entry remains and reads 0 once the buffer is empty.
- R5: Address 1 reads {4'b0000, S-channel code}, and the S-channel code is sampled every cycle. When a sample differs from the previous one, status bit 7 sets. A read of address 1 clears bit 7.
- R6: If an S-channel change arrives in the same cycle as a read of address 1, status bit 7 stays set.
- R7: While `slave_mode` is 1, status bit 7 is held at 0, and address 1 still tracks the S-channel code.
- R8: Address 2 stores all 8 written bits and reads them back. `cmd_code_o` equals bits 3..0 of that register.
- R9: Writes to address 0 and address 1 change nothing, and reads of address 3 return 0x00.
- R10: When `soft_rst` is 1 at a rising edge, every register returns to its R1 value and the buffer empties.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous reset of all registers |
| slave_mode | input | 1 | Codes come from an external transceiver; S-channel flag unused |
| ind_code_i | input | 4 | Received layer-1 indication code |
| sch_code_i | input | 4 | Received S-channel code |
| addr | input | 2 | Host register address |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (triggers read side effects) |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data for `addr` |
| cmd_code_o | output | 4 | Outgoing command code |

## Verification
The bench sweeps every pair of indication codes after a soft reset. This pair sweep exposes three faults:
- a design that queues repeated codes, or ignores the reset value 4'hF as the comparison base, reads back extra or missing entries;
- a design that drops bit 6 after the first read of two entries shows bit 6 at 0 on the second read;
- a design that overwrites the oldest entry when full returns the wrong first code.

A separate sweep drives a third code into a full buffer to check the overwrite case. The S-channel tests check three more faults:
- a flag set on an unchanged code;
- a flag still set after a read of address 1;
- a design that lets the clear win over a same-cycle change, which shows bit 7 at 0 after that read.

The remaining tests check that writes to the read-only addresses leave them unchanged, and that slave mode and a soft reset return each register to its reset value.

// File: rtl/l1ind_pkg.sv
package l1ind_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_STAT = 2'd0,
    REG_SCH  = 2'd1,
    REG_CMD  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam logic [7:0] RST_BYTE = 8'h0F;
endpackage

// File: rtl/l1ind_queue.sv
module l1ind_queue #(
  parameter int              W     = 4,
  parameter int              DEPTH = 2,
  parameter logic [W-1:0]    INIT  = '1,
  localparam int             CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [W-1:0]     code_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic             nonempty_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [W-1:0]     last_q;
  logic [W-1:0]     mem_q [DEPTH];
  logic [W-1:0]     mem_n [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             push, pop_eff;

  assign push    = (code_i != last_q);
  assign pop_eff = pop_i && (cnt_q != '0);

  always_comb begin
    mem_n = mem_q;
    cnt_n = cnt_q;
    if (pop_eff) begin
      for (int i = 0; i < DEPTH - 1; i++) mem_n[i] = mem_q[i+1];
      cnt_n = cnt_q - CNT_W'(1);
    end
    if (push) begin
      if (cnt_n == FULL) begin
        mem_n[DEPTH-1] = code_i;
      end else begin
        for (int i = 0; i < DEPTH; i++)
          if (CNT_W'(i) == cnt_n) mem_n[i] = code_i;
        cnt_n = cnt_n + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= INIT;
      cnt_q  <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= INIT;
    end else if (clr) begin
      last_q <= INIT;
      cnt_q  <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= INIT;
    end else begin
      if (push) last_q <= code_i;
      cnt_q <= cnt_n;
      mem_q <= mem_n;
    end
  end

  assign nonempty_o = (cnt_q != '0);
  assign head_o     = nonempty_o ? mem_q[0] : last_q;
  assign count_o    = cnt_q;
endmodule

// File: rtl/l1ind_sch_track.sv
module l1ind_sch_track #(
  parameter int           W    = 4,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         slave_i,
  input  logic [W-1:0] sch_i,
  input  logic         ack_i,
  output logic [W-1:0] last_o,
  output logic         flag_o
);
  logic [W-1:0] last_q;
  logic         flag_q;
  logic         change;

  assign change = (sch_i != last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= INIT;
      flag_q <= 1'b0;
    end else if (clr) begin
      last_q <= INIT;
      flag_q <= 1'b0;
    end else begin
      last_q <= sch_i;
      if (slave_i)     flag_q <= 1'b0;
      else if (change) flag_q <= 1'b1;
      else if (ack_i)  flag_q <= 1'b0;
    end
  end

  assign last_o = last_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/l1ind_regs.sv
module l1ind_regs
  import l1ind_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int DATA_W = 8,
  parameter int QDEPTH = 2,
  localparam int CNT_W = $clog2(QDEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              slave_mode,
  input  logic [CODE_W-1:0] ind_code_i,
  input  logic [CODE_W-1:0] sch_code_i,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [CODE_W-1:0] cmd_code_o
);
  localparam int               PAD_W   = DATA_W - 2 - CODE_W;
  localparam logic [CODE_W-1:0] CODE_INIT = '1;

  logic              rd_stat, rd_sch, wr_cmd;
  logic [CODE_W-1:0] ind_head;
  logic              ind_flag;
  logic [CNT_W-1:0]  q_cnt;
  logic [CODE_W-1:0] sch_last;
  logic              sch_flag;
  logic [DATA_W-1:0] cmd_q;

  assign rd_stat = rd_en && (addr == REG_STAT);
  assign rd_sch  = rd_en && (addr == REG_SCH);
  assign wr_cmd  = wr_en && (addr == REG_CMD);

  l1ind_queue #(.W(CODE_W), .DEPTH(QDEPTH), .INIT(CODE_INIT)) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (soft_rst),
    .code_i     (ind_code_i),
    .pop_i      (rd_stat),
    .head_o     (ind_head),
    .nonempty_o (ind_flag),
    .count_o    (q_cnt)
  );

  l1ind_sch_track #(.W(CODE_W), .INIT(CODE_INIT)) u_sch (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (soft_rst),
    .slave_i (slave_mode),
    .sch_i   (sch_code_i),
    .ack_i   (rd_sch),
    .last_o  (sch_last),
    .flag_o  (sch_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cmd_q <= DATA_W'(RST_BYTE);
    else if (soft_rst) cmd_q <= DATA_W'(RST_BYTE);
    else if (wr_cmd)   cmd_q <= wdata;
  end

  assign cmd_code_o = cmd_q[CODE_W-1:0];

  always_comb begin
    case (addr)
      REG_STAT: rdata = {sch_flag, ind_flag, {PAD_W{1'b0}}, ind_head};
      REG_SCH:  rdata = {{(DATA_W-CODE_W){1'b0}}, sch_last};
      REG_CMD:  rdata = cmd_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/l1ind_regs_chk.sv
module l1ind_regs_chk
  import l1ind_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int DATA_W = 8,
  parameter int QDEPTH = 2,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              slave_mode,
  input logic [CODE_W-1:0] sch_code_i,
  input logic [CODE_W-1:0] sch_last,
  input logic              sch_flag,
  input logic              ind_flag,
  input logic [CNT_W-1:0]  q_cnt,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_en,
  input logic              wr_en,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] cmd_q
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= CNT_W'(QDEPTH));

  assert_flag_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == REG_STAT && q_cnt > CNT_W'(1) && !soft_rst) |=> ind_flag);

  assert_sch_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == REG_SCH && sch_code_i == sch_last) |=> !sch_flag);

  assert_sch_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == REG_SCH && sch_code_i != sch_last && !slave_mode && !soft_rst)
      |=> sch_flag);

  assert_slave_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |=> !sch_flag);

  assert_cmd_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_CMD && !soft_rst) |=> (cmd_q == $past(wdata)));

  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (q_cnt == '0 && cmd_q == DATA_W'(RST_BYTE) && !sch_flag));
endmodule

bind l1ind_regs l1ind_regs_chk #(
  .CODE_W(CODE_W), .DATA_W(DATA_W), .QDEPTH(QDEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_rst   (soft_rst),
  .slave_mode (slave_mode),
  .sch_code_i (sch_code_i),
  .sch_last   (sch_last),
  .sch_flag   (sch_flag),
  .ind_flag   (ind_flag),
  .q_cnt      (q_cnt),
  .addr       (addr),
  .rd_en      (rd_en),
  .wr_en      (wr_en),
  .wdata      (wdata),
  .cmd_q      (cmd_q)
);

// File: tb/l1ind_regs_bench.sv
module l1ind_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       slave_mode = 1'b0;
  logic [3:0] ind_code_i = 4'hF;
  logic [3:0] sch_code_i = 4'hF;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [3:0] cmd_code_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [3:0] m_last, m_q0, m_q1;
  int         m_n;

  l1ind_regs u_l1ind_regs (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .slave_mode(slave_mode),
    .ind_code_i(ind_code_i), .sch_code_i(sch_code_i), .addr(addr),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
    .cmd_code_o(cmd_code_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic set_ind(input logic [3:0] v);
    @(negedge clk); ind_code_i = v;
    @(posedge clk); #1;
  endtask

  task automatic set_sch(input logic [3:0] v);
    @(negedge clk); sch_code_i = v;
    @(posedge clk); #1;
  endtask

  task automatic do_soft_reset();
    @(negedge clk);
    ind_code_i = 4'hF; sch_code_i = 4'hF; soft_rst = 1'b1;
    @(posedge clk); #1 soft_rst = 1'b0;
    m_last = 4'hF; m_n = 0; m_q0 = 4'hF; m_q1 = 4'hF;
  endtask

  task automatic model_push(input logic [3:0] v);
    if (v != m_last) begin
      m_last = v;
      if (m_n == 0) begin m_q0 = v; m_n = 1; end
      else if (m_n == 1) begin m_q1 = v; m_n = 2; end
      else m_q1 = v;
    end
  endtask

  task automatic model_read_check(input string req);
    logic [7:0] d, exp;
    exp = {1'b0, (m_n != 0), 2'b00, (m_n != 0) ? m_q0 : m_last};
    rd(2'd0, d);
    check(req, d, exp);
    if (m_n == 2) begin m_q0 = m_q1; m_n = 1; end
    else if (m_n == 1) m_n = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, d); check("R1 status", d, 8'h0F);
    rd(2'd1, d); check("R1 schan", d, 8'h0F);
    rd(2'd2, d); check("R1 cmd", d, 8'h0F);
    check("R1 cmd_code_o", {4'h0, cmd_code_o}, 8'h0F);

    // R2 R4: every pair of indication codes
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        do_soft_reset();
        set_ind(4'(a)); model_push(4'(a));
        set_ind(4'(b)); model_push(4'(b));
        model_read_check("R2/R4 pair read1");
        model_read_check("R4 pair read2");
        model_read_check("R4 pair read3");
      end
    end

    // R3 overwrite of newest entry when full
    for (int c = 0; c < 16; c++) begin
      do_soft_reset();
      set_ind(4'h1); model_push(4'h1);
      set_ind(4'h2); model_push(4'h2);
      set_ind(4'(c)); model_push(4'(c));
      model_read_check("R3 full read1");
      model_read_check("R3 full read2");
      model_read_check("R3 full read3");
    end

    // R5 S-channel sweep
    do_soft_reset();
    for (int s = 0; s < 16; s++) begin
      set_sch(4'(s));
      rd(2'd0, d); check("R5 flag set", d, 8'h8F);
      rd(2'd1, d); check("R5 schan value", d, {4'h0, 4'(s)});
      rd(2'd0, d); check("R5 flag cleared", d, 8'h0F);
    end
    set_sch(4'hF);
    rd(2'd0, d); check("R5 unchanged no flag", d, 8'h0F);

    // R6 change during S-channel read keeps flag
    @(negedge clk);
    sch_code_i = 4'h3; addr = 2'd1; rd_en = 1'b1;
    #1 check("R6 old value", rdata, 8'h0F);
    @(posedge clk); #1 rd_en = 1'b0;
    rd(2'd0, d); check("R6 flag kept", d, 8'h8F);
    rd(2'd1, d); check("R6 new value", d, 8'h03);
    rd(2'd0, d); check("R6 flag then cleared", d, 8'h0F);

    // R7 slave mode
    @(negedge clk); slave_mode = 1'b1;
    set_sch(4'h9);
    rd(2'd0, d); check("R7 flag held low", d, 8'h0F);
    rd(2'd1, d); check("R7 schan tracks", d, 8'h09);
    @(negedge clk); slave_mode = 1'b0;

    // R8 command register sweep
    for (int v = 0; v < 256; v++) begin
      wr(2'd2, 8'(v));
      check("R8 cmd_code_o", {4'h0, cmd_code_o}, {4'h0, 4'(v)});
      rd(2'd2, d); check("R8 cmd readback", d, 8'(v));
    end

    // R9 ignored writes and unused address
    do_soft_reset();
    wr(2'd0, 8'hA5);
    rd(2'd0, d); check("R9 status write ignored", d, 8'h0F);
    wr(2'd1, 8'h5A);
    rd(2'd1, d); check("R9 schan write ignored", d, 8'h0F);
    rd(2'd3, d); check("R9 unused reads zero", d, 8'h00);
    set_ind(4'h4);
    wr(2'd0, 8'h00);
    rd(2'd0, d); check("R9 pending entry kept", d, 8'h44);

    // R10 soft reset
    set_ind(4'h2);
    set_sch(4'h6);
    wr(2'd2, 8'h33);
    do_soft_reset();
    rd(2'd0, d); check("R10 status", d, 8'h0F);
    rd(2'd1, d); check("R10 schan", d, 8'h0F);
    rd(2'd2, d); check("R10 cmd", d, 8'h0F);
    check("R10 cmd_code_o", {4'h0, cmd_code_o}, 8'h0F);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule